// File: doc/BRIEF.md
# External Data Address Generator

This block builds the 16-bit address, write data and strobes that an 8051-style processor core presents to a synchronous external data RAM during its MOVX transfers. The core has already decoded the instruction. It tells the block which of two addressing modes applies and supplies the register byte, a read or write strobe, and the byte to store.

In paged mode, the register byte (R0 or R1 of the current bank) gives the low address byte and a page register gives the high byte. The 64 KB space is therefore seen as 256 pages of 256 bytes. In pointer mode, one of two 16-bit data pointers gives the whole address, and the page register plays no part. A select register picks the active pointer. The two modes can be mixed freely from one access to the next, so software has four independent handles into the same 64 KB.

Special-function-register writes load the page register, the select register, or either byte of the active pointer. A separate pulse increments the active pointer, which is useful for block copies. The RAM registers the address and returns read data on the clock after the address is presented. That data goes straight to the core.

Top module: `xdata_addr_gen`

## Requirements
- R1: After reset the page register, the select register and both pointers hold zero, so pointer mode addresses 0x0000 and paged mode addresses {0x00, reg_byte}.
- R2: When acc_kind is 0 (paged mode), mem_addr equals {page register, reg_byte} in the same cycle.
- R3: When acc_kind is 1 (pointer mode), mem_addr equals the active pointer in the same cycle, whatever the page register holds.
- R4: An SFR write with sfr_sel = 1 stores only bit 0 of sfr_wdata as the select. Select 0 makes pointer 0 active, select 1 makes pointer 1 active, and bits 7:1 have no effect.
- R5: An SFR write with sfr_sel = 2 loads the low byte, and one with sfr_sel = 3 loads the high byte, of the active pointer only. The inactive pointer keeps its value.
- R6: A ptr_inc pulse adds one to the active pointer, carries from the low byte into the high byte, wraps 0xFFFF to 0x0000, and leaves the inactive pointer unchanged.
- R7: When a pointer byte load and ptr_inc occur in the same cycle, the load takes effect and the increment is dropped.
- R8: rd_stb alone raises mem_rd_en in that cycle. wr_stb alone raises mem_wr_en for exactly the cycles it is high, and drives mem_wdata = wr_data. When no write is in progress, mem_wdata is 0x00.
- R9: If rd_stb and wr_stb are both high, neither enable is raised.
- R10: An access in the same cycle as an SFR write (sfr_sel = 0 for page) uses the register values from before that write. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 1 | 0 paged (register-indirect), 1 data-pointer |
| reg_byte | input | 8 | R0/R1 value for paged mode |
| rd_stb | input | 1 | Read access this cycle |
| wr_stb | input | 1 | Write access this cycle |
| wr_data | input | 8 | Byte to store |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_sel | input | 2 | SFR target: 0 page, 1 select, 2 pointer low, 3 pointer high |
| sfr_wdata | input | 8 | SFR write byte |
| ptr_inc | input | 1 | Increment active pointer |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rd_en | output | 1 | RAM read enable |
| mem_wr_en | output | 1 | RAM write enable |

## Verification
A wrong page or pointer value shows at mem_addr in the first cycle that uses the affected mode, because the address path is combinational from the registers. A corrupted inactive pointer stays hidden until the select changes. For that reason the bench switches the select back and confirms the earlier value of each pointer. A mis-steered load, a lost carry or a dropped wrap shows one cycle after the faulty update, on the next pointer-mode access.

// File: rtl/xdag_pkg.sv
package xdag_pkg;
  typedef enum logic {ACC_PAGED = 1'b0, ACC_POINTER = 1'b1} acc_kind_e;
  typedef enum logic [1:0] {
    TGT_PAGE   = 2'd0,
    TGT_SELECT = 2'd1,
    TGT_PTR_LO = 2'd2,
    TGT_PTR_HI = 2'd3
  } sfr_tgt_e;

  function automatic logic [15:0] ptr_step(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  function automatic logic [15:0] paged_addr(input logic [7:0] page, input logic [7:0] lo);
    return {page, lo};
  endfunction
endpackage

// File: rtl/xdag_ptr_bank.sv
module xdag_ptr_bank #(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 2,
  localparam int PTR_W   = 2 * BYTE_W,
  localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_wr,
  input  logic [SEL_W-1:0]          sel_wdata,
  input  logic                      ld_lo,
  input  logic                      ld_hi,
  input  logic [BYTE_W-1:0]         ld_data,
  input  logic                      inc,
  output logic [SEL_W-1:0]          sel_q,
  output logic [PTR_W-1:0]          active_ptr,
  output logic [NUM_PTRS*PTR_W-1:0] ptr_flat
);
  logic [PTR_W-1:0] ptr_q [NUM_PTRS];

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_wdata;
  end

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    logic is_act;
    assign is_act = (sel_q == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)                ptr_q[i] <= '0;
      else if (is_act && ld_lo)  ptr_q[i][BYTE_W-1:0] <= ld_data;
      else if (is_act && ld_hi)  ptr_q[i][PTR_W-1:BYTE_W] <= ld_data;
      else if (is_act && inc)    ptr_q[i] <= xdag_pkg::ptr_step(ptr_q[i]);
    end
    assign ptr_flat[i*PTR_W +: PTR_W] = ptr_q[i];
  end

  always_comb begin
    active_ptr = '0;
    for (int k = 0; k < NUM_PTRS; k++)
      if (sel_q == SEL_W'(k)) active_ptr = ptr_q[k];
  end
endmodule

// File: rtl/xdag_addr_mux.sv
module xdag_addr_mux #(
  parameter int BYTE_W  = 8,
  localparam int PTR_W  = 2 * BYTE_W
) (
  input  logic              kind,
  input  logic [BYTE_W-1:0] page,
  input  logic [BYTE_W-1:0] reg_byte,
  input  logic [PTR_W-1:0]  active_ptr,
  output logic [PTR_W-1:0]  addr
);
  import xdag_pkg::*;
  always_comb begin
    if (acc_kind_e'(kind) == ACC_POINTER) addr = active_ptr;
    else                                  addr = paged_addr(page, reg_byte);
  end
endmodule

// File: rtl/xdata_addr_gen.sv
module xdata_addr_gen #(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 2,
  localparam int PTR_W   = 2 * BYTE_W,
  localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_kind,
  input  logic [BYTE_W-1:0] reg_byte,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sfr_wr,
  input  logic [1:0]        sfr_sel,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic              ptr_inc,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en
);
  import xdag_pkg::*;

  logic [BYTE_W-1:0]         page_q;
  logic [SEL_W-1:0]          sel_q;
  logic [PTR_W-1:0]          active_ptr;
  logic [NUM_PTRS*PTR_W-1:0] ptr_flat;
  logic page_ld, sel_ld, lo_ld, hi_ld;
  logic ld_fire, inc_fire;

  assign page_ld  = sfr_wr && (sfr_tgt_e'(sfr_sel) == TGT_PAGE);
  assign sel_ld   = sfr_wr && (sfr_tgt_e'(sfr_sel) == TGT_SELECT);
  assign lo_ld    = sfr_wr && (sfr_tgt_e'(sfr_sel) == TGT_PTR_LO);
  assign hi_ld    = sfr_wr && (sfr_tgt_e'(sfr_sel) == TGT_PTR_HI);
  assign ld_fire  = lo_ld || hi_ld;
  assign inc_fire = ptr_inc;

  always_ff @(posedge clk) begin
    if (!rst_n)       page_q <= '0;
    else if (page_ld) page_q <= sfr_wdata;
  end

  xdag_ptr_bank #(.BYTE_W(BYTE_W), .NUM_PTRS(NUM_PTRS)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_ld),
    .sel_wdata  (sfr_wdata[SEL_W-1:0]),
    .ld_lo      (lo_ld),
    .ld_hi      (hi_ld),
    .ld_data    (sfr_wdata),
    .inc        (inc_fire),
    .sel_q      (sel_q),
    .active_ptr (active_ptr),
    .ptr_flat   (ptr_flat)
  );

  xdag_addr_mux #(.BYTE_W(BYTE_W)) u_mux (
    .kind       (acc_kind),
    .page       (page_q),
    .reg_byte   (reg_byte),
    .active_ptr (active_ptr),
    .addr       (mem_addr)
  );

  assign mem_rd_en = rd_stb && !wr_stb;
  assign mem_wr_en = wr_stb && !rd_stb;
  assign mem_wdata = mem_wr_en ? wr_data : '0;
endmodule

// File: rtl/xdag_checks.sv
module xdag_checks #(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 2,
  localparam int PTR_W   = 2 * BYTE_W,
  localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_kind,
  input logic [BYTE_W-1:0]         reg_byte,
  input logic                      rd_stb,
  input logic                      wr_stb,
  input logic [BYTE_W-1:0]         page_q,
  input logic [SEL_W-1:0]          sel_q,
  input logic [NUM_PTRS*PTR_W-1:0] ptr_flat,
  input logic                      ld_fire,
  input logic                      inc_fire,
  input logic [PTR_W-1:0]          mem_addr,
  input logic                      mem_rd_en,
  input logic                      mem_wr_en
);
  logic [PTR_W-1:0] p0, p1;
  assign p0 = ptr_flat[0 +: PTR_W];
  assign p1 = ptr_flat[PTR_W +: PTR_W];

  assert_paged_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 1'b0) |-> (mem_addr == {page_q, reg_byte}));

  assert_ptr_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 1'b1) |-> (mem_addr == ((sel_q == '0) ? p0 : p1)));

  assert_idle_p1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> $stable(p1));

  assert_idle_p0_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != '0) |=> $stable(p0));

  assert_inc_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && !ld_fire && sel_q == '0) |=> (p0 == PTR_W'($past(p0) + 1'b1)));

  assert_inc_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && !ld_fire && sel_q != '0) |=> (p1 == PTR_W'($past(p1) + 1'b1)));

  assert_wr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (wr_stb && !rd_stb));

  assert_no_dual_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

bind xdata_addr_gen xdag_checks #(.BYTE_W(BYTE_W), .NUM_PTRS(NUM_PTRS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_kind (acc_kind),
  .reg_byte (reg_byte),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .page_q   (page_q),
  .sel_q    (sel_q),
  .ptr_flat (ptr_flat),
  .ld_fire  (ld_fire),
  .inc_fire (inc_fire),
  .mem_addr (mem_addr),
  .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en)
);

// File: tb/xdata_addr_gen_test.sv
`timescale 1ns/1ps
module xdata_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_kind, rd_stb, wr_stb, sfr_wr, ptr_inc;
  logic [7:0] reg_byte, wr_data, sfr_wdata, mem_wdata;
  logic [1:0] sfr_sel;
  logic [15:0] mem_addr;
  logic mem_rd_en, mem_wr_en;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xdata_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .reg_byte(reg_byte),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .sfr_wr(sfr_wr),
    .sfr_sel(sfr_sel), .sfr_wdata(sfr_wdata), .ptr_inc(ptr_inc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en)
  );

  // kind | reg | sfr_wr | sfr_sel | sfr_wdata | inc | expected address
  localparam logic [36:0] VEC [20] = '{
    {1'b0, 8'h34, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0034},  // R1 page zero
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0000},  // R1 pointer zero
    {1'b0, 8'h12, 1'b1, 2'd0, 8'hAB, 1'b0, 16'h0012},  // R10 old page
    {1'b0, 8'h56, 1'b0, 2'd0, 8'h00, 1'b0, 16'hAB56},  // R2
    {1'b1, 8'h00, 1'b1, 2'd2, 8'h78, 1'b0, 16'h0000},  // R3 page ignored
    {1'b1, 8'h00, 1'b1, 2'd3, 8'h12, 1'b0, 16'h0078},  // R5 low loaded
    {1'b1, 8'h00, 1'b1, 2'd1, 8'hFE, 1'b0, 16'h1278},  // R4 upper bits ignored
    {1'b1, 8'h00, 1'b1, 2'd1, 8'h01, 1'b0, 16'h1278},  // R4 still pointer 0
    {1'b1, 8'h00, 1'b1, 2'd2, 8'hFF, 1'b0, 16'h0000},  // R4 pointer 1 active
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 16'h00FF},  // R5 load into pointer 1
    {1'b1, 8'h00, 1'b1, 2'd3, 8'hFF, 1'b0, 16'h0100},  // R6 carry
    {1'b1, 8'h00, 1'b1, 2'd2, 8'hFF, 1'b0, 16'hFF00},
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 16'hFFFF},
    {1'b1, 8'h00, 1'b1, 2'd1, 8'h00, 1'b0, 16'h0000},  // R6 wrap
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 16'h1278},  // R5 pointer 0 kept
    {1'b1, 8'h00, 1'b1, 2'd2, 8'h40, 1'b1, 16'h1278},
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 16'h1240},  // R7 load wins
    {1'b0, 8'h01, 1'b0, 2'd0, 8'h00, 1'b0, 16'hAB01},  // R2 interleaved
    {1'b1, 8'h00, 1'b1, 2'd1, 8'h03, 1'b0, 16'h1240},
    {1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0000}   // R6 pointer 1 after wrap
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_kind = 1'b0; reg_byte = 8'h00; rd_stb = 1'b0; wr_stb = 1'b0;
    wr_data = 8'h00; sfr_wr = 1'b0; sfr_sel = 2'd0; sfr_wdata = 8'h00; ptr_inc = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R8", {14'd0, mem_rd_en, mem_wr_en}, 16'h0000);

    for (int i = 0; i < 20; i++) begin
      {acc_kind, reg_byte, sfr_wr, sfr_sel, sfr_wdata, ptr_inc} = VEC[i][36:16];
      #1;
      chk($sformatf("vector %0d R2/R3/R4/R5/R6/R7/R10", i), mem_addr, VEC[i][15:0]);
      @(negedge clk);
    end
    idle();

    rd_stb = 1'b1;
    #1 chk("R8 read", {14'd0, mem_rd_en, mem_wr_en}, 16'h0002);
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b1; wr_data = 8'h5A;
    #1 chk("R8 write", {14'd0, mem_rd_en, mem_wr_en}, 16'h0001);
    chk("R8 wdata", {8'h00, mem_wdata}, 16'h005A);
    @(negedge clk);
    wr_stb = 1'b0;
    #1 chk("R8 one cycle", {14'd0, mem_rd_en, mem_wr_en}, 16'h0000);
    chk("R8 idle wdata", {8'h00, mem_wdata}, 16'h0000);
    @(negedge clk);
    rd_stb = 1'b1; wr_stb = 1'b1;
    #1 chk("R9", {14'd0, mem_rd_en, mem_wr_en}, 16'h0000);
    chk("R9 wdata", {8'h00, mem_wdata}, 16'h0000);
    @(negedge clk);
    idle();

    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    acc_kind = 1'b1;
    #1 chk("R1 pointer after reset", mem_addr, 16'h0000);
    @(negedge clk);
    acc_kind = 1'b0; reg_byte = 8'h77;
    #1 chk("R1 page after reset", mem_addr, 16'h0077);
    @(negedge clk);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule